// File: doc/BRIEF.md
# Rate-Trimmed Time-of-Day Counter for Precision Time Protocol

This block keeps a time-of-day value made of three fields: a whole-seconds count, a nanoseconds count that wraps once per second, and a fractional sub-nanosecond accumulator. It advances on every edge of a 10 ns reference clock. The fractional accumulator adds a host-chosen trim value on each edge. Each time the accumulator carries out, that cycle's nanosecond step becomes one larger or one smaller than the nominal step. Over many cycles this lets a servo pull the counter's frequency very finely toward a master clock.

The host can also correct the clock in one step. It can load all three fields at once, add a signed amount to the seconds field, or add a positive amount to the nanoseconds field. It can also run with a second trim value and direction for a programmed number of reference cycles, after which the normal trim takes over again. The host starts each command by pulsing a start input; the value fields are held steady on level inputs. A four-bit status output shows which commands are in effect. The outputs give the current value of all three fields.

Top module: `ptp_tod_clock`

## Requirements
- R1: While `rst_n` is low, and for two clock edges after it rises, the seconds, nanoseconds and sub-nanosecond outputs and all four status bits are zero.
- R2: In a cycle with no load or step in effect, the sub-nanosecond field becomes (field + active trim) modulo 2^SUBNS_W. If that sum does not carry out, the nanoseconds field advances by NOM_INC.
- R3: When the sub-nanosecond sum carries out, the nanoseconds field advances by NOM_INC+1 if the active direction bit is 1, and by NOM_INC-1 if it is 0.
- R4: When the new nanoseconds value would reach NS_ROLL or more, NS_ROLL is subtracted from it and the seconds field increments modulo 2^SEC_W. The nanoseconds output is then always below NS_ROLL.
- R5: Status bit 0 is the load bit. One edge after a `go_load_i` pulse, the bit is set. At the next edge, the three fields take the values on `load_sec_i`, `load_ns_i` and `load_sub_i`.
- R6: Status bit 1 is the seconds-step bit. At the edge that acts on it, `step_val_i` (low SEC_W bits) is added to the seconds field if `step_neg_i` is 0 and subtracted if it is 1. Any nanoseconds rollover in the same cycle also adds one. The nanoseconds and sub-nanosecond fields advance as in R2 to R4.
- R7: Status bit 2 is the nanoseconds-step bit. At the edge that acts on it, `step_val_i` (less than NS_ROLL) is added to the nanoseconds field in place of the normal increment, so a carry-out of the accumulator in that cycle has no effect. Rollover works as in R4. The sub-nanosecond field still advances by the active trim.
- R8: If the load bit is set, both step bits are ignored in that cycle. If both step bits are set without a load, both steps apply in the same cycle.
- R9: Status bit 3 is the temporary-rate bit. While it is set, `tmp_rate_i` and `tmp_fast_i` replace `rate_adj_i` and `rate_fast_i`. A `go_tmp_i` pulse sets the bit for exactly `tmp_len_i` cycles, with a length of 0 treated as 1. After that the bit clears and the normal trim applies again.
- R10: The load and step status bits each stay set for exactly one cycle per start pulse.
- R11: A `go_tmp_i` pulse while the temporary-rate bit is set restarts the count with the new `tmp_len_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one tick per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_adj_i | input | SUBNS_W | Normal trim added to the accumulator each cycle |
| rate_fast_i | input | 1 | Normal trim direction, 1 speeds up |
| tmp_rate_i | input | SUBNS_W | Trim used while the temporary-rate bit is set |
| tmp_fast_i | input | 1 | Temporary trim direction, 1 speeds up |
| tmp_len_i | input | DUR_W | Temporary-rate length in cycles |
| load_sec_i | input | SEC_W | Seconds value for a load |
| load_ns_i | input | NS_W | Nanoseconds value for a load, below NS_ROLL |
| load_sub_i | input | SUBNS_W | Sub-nanosecond value for a load |
| step_val_i | input | STEP_W | Step amount for the seconds or nanoseconds step |
| step_neg_i | input | 1 | Seconds step direction, 1 subtracts |
| go_load_i | input | 1 | Start pulse for a load |
| go_step_sec_i | input | 1 | Start pulse for a seconds step |
| go_step_ns_i | input | 1 | Start pulse for a nanoseconds step |
| go_tmp_i | input | 1 | Start pulse for a temporary rate |
| sec_o | output | SEC_W | Seconds field |
| ns_o | output | NS_W | Nanoseconds field |
| sub_o | output | SUBNS_W | Sub-nanosecond accumulator |
| cmd_busy_o | output | 4 | Status bits: 0 load, 1 seconds step, 2 nanoseconds step, 3 temporary rate |

## Verification
The bench builds the block with an 8-bit seconds field, an 8-bit accumulator, a rollover of 100 and a 6-bit duration, keeping the nominal step of 10. With these values every trim value and both directions can be swept, and a nanoseconds rollover happens every ten cycles. The seconds field wraps after 256 seconds, so a step of every seconds value and every in-range nanoseconds amount lines up with accumulator carries and rollovers many times. An arithmetic model in the bench predicts all three fields and the status bits on every cycle.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;

  // status / command bit positions
  localparam int CMD_LD  = 0;
  localparam int CMD_SS  = 1;
  localparam int CMD_SN  = 2;
  localparam int CMD_TMP = 3;
  localparam int CMD_N   = 4;

  // resolved actions for the current cycle
  typedef struct packed {
    logic ld;
    logic step_sec;
    logic step_ns;
    logic tmp_act;
  } tod_fire_t;

endpackage

// File: rtl/ptp_tod_cmd.sv
module ptp_tod_cmd
  import ptp_tod_pkg::*;
#(
  parameter int DUR_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_ld_i,
  input  logic             set_ss_i,
  input  logic             set_sn_i,
  input  logic             set_tmp_i,
  input  logic [DUR_W-1:0] tmp_len_i,
  output tod_fire_t        fire_o,
  output logic [CMD_N-1:0] busy_o
);

  logic             ld_q, ss_q, sn_q, tmp_q;
  logic             ld_d, ss_d, sn_d, tmp_d;
  logic [DUR_W-1:0] rem_q, rem_d;

  // next state
  always_comb begin
    ld_d  = set_ld_i;
    ss_d  = set_ss_i;
    sn_d  = set_sn_i;
    tmp_d = tmp_q;
    rem_d = rem_q;
    if (set_tmp_i) begin
      tmp_d = 1'b1;
      rem_d = (tmp_len_i == '0) ? DUR_W'(1) : tmp_len_i;
    end else if (tmp_q) begin
      if (rem_q <= DUR_W'(1)) begin
        tmp_d = 1'b0;
        rem_d = '0;
      end else begin
        rem_d = rem_q - DUR_W'(1);
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q  <= 1'b0;
      ss_q  <= 1'b0;
      sn_q  <= 1'b0;
      tmp_q <= 1'b0;
      rem_q <= '0;
    end else begin
      ld_q  <= ld_d;
      ss_q  <= ss_d;
      sn_q  <= sn_d;
      tmp_q <= tmp_d;
      rem_q <= rem_d;
    end
  end

  // load wins over both steps; the two steps may combine
  always_comb begin
    fire_o.ld       = ld_q;
    fire_o.step_sec = ss_q & ~ld_q;
    fire_o.step_ns  = sn_q & ~ld_q;
    fire_o.tmp_act  = tmp_q;
  end

  always_comb begin
    busy_o          = '0;
    busy_o[CMD_LD]  = ld_q;
    busy_o[CMD_SS]  = ss_q;
    busy_o[CMD_SN]  = sn_q;
    busy_o[CMD_TMP] = tmp_q;
  end

  AST_TMP_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (tmp_q && (rem_q == DUR_W'(1)) && !set_tmp_i) |=> !tmp_q); // R9

  AST_TMP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (set_tmp_i && (tmp_len_i > DUR_W'(1))) |=> (tmp_q && (rem_q == $past(tmp_len_i)))); // R11

endmodule

// File: rtl/ptp_tod_rate.sv
module ptp_tod_rate #(
  parameter int SUBNS_W = 32,
  parameter int NS_W    = 30,
  parameter int NOM_INC = 10
) (
  input  logic [SUBNS_W-1:0] sub_q_i,
  input  logic [SUBNS_W-1:0] rate_i,
  input  logic               fast_i,
  input  logic [SUBNS_W-1:0] tmp_rate_i,
  input  logic               tmp_fast_i,
  input  logic               tmp_act_i,
  output logic [SUBNS_W-1:0] sub_adv_o,
  output logic [NS_W-1:0]    inc_o
);

  localparam logic [NS_W-1:0] INC_NOM  = NS_W'(NOM_INC);
  localparam logic [NS_W-1:0] INC_FAST = NS_W'(NOM_INC + 1);
  localparam logic [NS_W-1:0] INC_SLOW = NS_W'(NOM_INC - 1);

  logic [SUBNS_W-1:0] rate_sel;
  logic               fast_sel;
  logic [SUBNS_W:0]   acc_sum;
  logic               acc_wrap;

  always_comb begin
    rate_sel  = tmp_act_i ? tmp_rate_i : rate_i;
    fast_sel  = tmp_act_i ? tmp_fast_i : fast_i;
    acc_sum   = {1'b0, sub_q_i} + {1'b0, rate_sel};
    acc_wrap  = acc_sum[SUBNS_W];
    sub_adv_o = acc_sum[SUBNS_W-1:0];
    if (!acc_wrap)     inc_o = INC_NOM;
    else if (fast_sel) inc_o = INC_FAST;
    else               inc_o = INC_SLOW;
  end

endmodule

// File: rtl/ptp_tod_count.sv
module ptp_tod_count
  import ptp_tod_pkg::*;
#(
  parameter int SEC_W   = 32,
  parameter int SUBNS_W = 32,
  parameter int NS_ROLL = 1000000000,
  parameter int NOM_INC = 10,
  parameter int NS_W    = 30,
  parameter int STEP_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  tod_fire_t          fire_i,
  input  logic [SUBNS_W-1:0] sub_adv_i,
  input  logic [NS_W-1:0]    inc_i,
  input  logic [SEC_W-1:0]   ld_sec_i,
  input  logic [NS_W-1:0]    ld_ns_i,
  input  logic [SUBNS_W-1:0] ld_sub_i,
  input  logic [STEP_W-1:0]  step_val_i,
  input  logic               step_neg_i,
  output logic [SEC_W-1:0]   sec_o,
  output logic [NS_W-1:0]    ns_o,
  output logic [SUBNS_W-1:0] sub_o
);

  localparam int              SUM_W  = STEP_W + 1;
  localparam logic [SUM_W-1:0] ROLL_V = SUM_W'(NS_ROLL);

  logic [SEC_W-1:0]   sec_q, sec_d, sec_base;
  logic [NS_W-1:0]    ns_q, ns_d;
  logic [SUBNS_W-1:0] sub_q, sub_d;
  logic [SUM_W-1:0]   addend, ns_sum, ns_wrapped;
  logic               ns_carry;
  logic               fire_ld, fire_ss, fire_sn, any_fire;

  always_comb begin
    fire_ld  = fire_i.ld;
    fire_ss  = fire_i.step_sec;
    fire_sn  = fire_i.step_ns;
    any_fire = fire_ld | fire_ss | fire_sn;
  end

  // next state
  always_comb begin
    addend     = fire_sn ? SUM_W'(step_val_i) : SUM_W'(inc_i);
    ns_sum     = SUM_W'(ns_q) + addend;
    ns_carry   = (ns_sum >= ROLL_V);
    ns_wrapped = ns_carry ? (ns_sum - ROLL_V) : ns_sum;
    sec_base   = sec_q + SEC_W'(ns_carry);
    if (fire_ss) begin
      sec_d = step_neg_i ? (sec_base - SEC_W'(step_val_i))
                         : (sec_base + SEC_W'(step_val_i));
    end else begin
      sec_d = sec_base;
    end
    ns_d  = NS_W'(ns_wrapped);
    sub_d = sub_adv_i;
    if (fire_ld) begin
      sec_d = ld_sec_i;
      ns_d  = ld_ns_i;
      sub_d = ld_sub_i;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      ns_q  <= '0;
      sub_q <= '0;
    end else begin
      sec_q <= sec_d;
      ns_q  <= ns_d;
      sub_q <= sub_d;
    end
  end

  assign sec_o = sec_q;
  assign ns_o  = ns_q;
  assign sub_o = sub_q;

  AST_LOAD_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    fire_ld |=> ((sec_q == $past(ld_sec_i)) && (ns_q == $past(ld_ns_i))
                 && (sub_q == $past(ld_sub_i)))); // R5

  AST_NS_BELOW_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_ld |=> (int'(ns_q) < NS_ROLL)); // R4

  AST_SUB_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_sn && !fire_ld) |=> (sub_q == $past(sub_adv_i))); // R7

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !any_fire |=>
      (((int'(ns_q) >= int'($past(ns_q))) ?
         (int'(ns_q) - int'($past(ns_q))) :
         (int'(ns_q) + NS_ROLL - int'($past(ns_q)))) >= NOM_INC - 1) &&
      (((int'(ns_q) >= int'($past(ns_q))) ?
         (int'(ns_q) - int'($past(ns_q))) :
         (int'(ns_q) + NS_ROLL - int'($past(ns_q)))) <= NOM_INC + 1)); // R3

endmodule

// File: rtl/ptp_tod_clock.sv
module ptp_tod_clock
  import ptp_tod_pkg::*;
#(
  parameter int SEC_W   = 32,
  parameter int SUBNS_W = 32,
  parameter int NS_ROLL = 1000000000,
  parameter int NOM_INC = 10,
  parameter int DUR_W   = 30,
  localparam int NS_W   = $clog2(NS_ROLL),
  localparam int STEP_W = (SEC_W > NS_W) ? SEC_W : NS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SUBNS_W-1:0] rate_adj_i,
  input  logic               rate_fast_i,
  input  logic [SUBNS_W-1:0] tmp_rate_i,
  input  logic               tmp_fast_i,
  input  logic [DUR_W-1:0]   tmp_len_i,
  input  logic [SEC_W-1:0]   load_sec_i,
  input  logic [NS_W-1:0]    load_ns_i,
  input  logic [SUBNS_W-1:0] load_sub_i,
  input  logic [STEP_W-1:0]  step_val_i,
  input  logic               step_neg_i,
  input  logic               go_load_i,
  input  logic               go_step_sec_i,
  input  logic               go_step_ns_i,
  input  logic               go_tmp_i,
  output logic [SEC_W-1:0]   sec_o,
  output logic [NS_W-1:0]    ns_o,
  output logic [SUBNS_W-1:0] sub_o,
  output logic [CMD_N-1:0]   cmd_busy_o
);

  // reset: asserted asynchronously, released after two edges
  logic rst_s0_q, rst_s1_q, rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0_q <= 1'b0;
      rst_s1_q <= 1'b0;
    end else begin
      rst_s0_q <= 1'b1;
      rst_s1_q <= rst_s0_q;
    end
  end
  assign rst_core_n = rst_s1_q;

  tod_fire_t          fire;
  logic [SUBNS_W-1:0] sub_adv;
  logic [NS_W-1:0]    inc;

  ptp_tod_cmd #(
    .DUR_W (DUR_W)
  ) u_cmd (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .set_ld_i  (go_load_i),
    .set_ss_i  (go_step_sec_i),
    .set_sn_i  (go_step_ns_i),
    .set_tmp_i (go_tmp_i),
    .tmp_len_i (tmp_len_i),
    .fire_o    (fire),
    .busy_o    (cmd_busy_o)
  );

  ptp_tod_rate #(
    .SUBNS_W (SUBNS_W),
    .NS_W    (NS_W),
    .NOM_INC (NOM_INC)
  ) u_rate (
    .sub_q_i    (sub_o),
    .rate_i     (rate_adj_i),
    .fast_i     (rate_fast_i),
    .tmp_rate_i (tmp_rate_i),
    .tmp_fast_i (tmp_fast_i),
    .tmp_act_i  (fire.tmp_act),
    .sub_adv_o  (sub_adv),
    .inc_o      (inc)
  );

  ptp_tod_count #(
    .SEC_W   (SEC_W),
    .SUBNS_W (SUBNS_W),
    .NS_ROLL (NS_ROLL),
    .NOM_INC (NOM_INC),
    .NS_W    (NS_W),
    .STEP_W  (STEP_W)
  ) u_count (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .fire_i     (fire),
    .sub_adv_i  (sub_adv),
    .inc_i      (inc),
    .ld_sec_i   (load_sec_i),
    .ld_ns_i    (load_ns_i),
    .ld_sub_i   (load_sub_i),
    .step_val_i (step_val_i),
    .step_neg_i (step_neg_i),
    .sec_o      (sec_o),
    .ns_o       (ns_o),
    .sub_o      (sub_o)
  );

  AST_ONESHOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cmd_busy_o[CMD_LD] && !go_load_i) |=> !cmd_busy_o[CMD_LD]); // R10

endmodule

// File: tb/ptp_tod_clock_bench.sv
module ptp_tod_clock_bench;

  localparam int SEC_W   = 8;
  localparam int SUBNS_W = 8;
  localparam int NS_ROLL = 100;
  localparam int NOM_INC = 10;
  localparam int DUR_W   = 6;
  localparam int NS_W    = 7;
  localparam int STEP_W  = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [SUBNS_W-1:0] rate_adj = '0, tmp_rate = '0, load_sub = '0;
  logic               rate_fast = 1'b0, tmp_fast = 1'b0, step_neg = 1'b0;
  logic [DUR_W-1:0]   tmp_len = '0;
  logic [SEC_W-1:0]   load_sec = '0;
  logic [NS_W-1:0]    load_ns = '0;
  logic [STEP_W-1:0]  step_val = '0;
  logic               go_ld = 1'b0, go_ss = 1'b0, go_sn = 1'b0, go_tmp = 1'b0;
  logic [SEC_W-1:0]   sec;
  logic [NS_W-1:0]    ns;
  logic [SUBNS_W-1:0] sub;
  logic [3:0]         busy;

  ptp_tod_clock #(
    .SEC_W (SEC_W), .SUBNS_W (SUBNS_W), .NS_ROLL (NS_ROLL),
    .NOM_INC (NOM_INC), .DUR_W (DUR_W)
  ) u_ptp_tod_clock (
    .clk (clk), .rst_n (rst_n),
    .rate_adj_i (rate_adj), .rate_fast_i (rate_fast),
    .tmp_rate_i (tmp_rate), .tmp_fast_i (tmp_fast), .tmp_len_i (tmp_len),
    .load_sec_i (load_sec), .load_ns_i (load_ns), .load_sub_i (load_sub),
    .step_val_i (step_val), .step_neg_i (step_neg),
    .go_load_i (go_ld), .go_step_sec_i (go_ss), .go_step_ns_i (go_sn),
    .go_tmp_i (go_tmp),
    .sec_o (sec), .ns_o (ns), .sub_o (sub), .cmd_busy_o (busy)
  );

  always #5 clk = ~clk;

  int    n_vec = 0;
  int    n_bad = 0;
  int    cyc   = 0;
  string tag   = "R1";

  // arithmetic model built from the requirements
  int m_sec, m_ns, m_sub, m_rem;
  bit m_ld, m_ss, m_sn, m_tp, m_r0, m_r1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sec = 0; m_ns = 0; m_sub = 0; m_rem = 0;
      m_ld = 0; m_ss = 0; m_sn = 0; m_tp = 0; m_r0 = 0; m_r1 = 0;
    end else begin
      if (m_r1) begin
        int r, s, inc, t, c;
        bit f;
        r = m_tp ? int'(tmp_rate) : int'(rate_adj);
        f = m_tp ? tmp_fast : rate_fast;
        s = m_sub + r;
        inc = (s >= 256) ? (f ? NOM_INC + 1 : NOM_INC - 1) : NOM_INC;
        if (m_ld) begin
          m_sec = int'(load_sec); m_ns = int'(load_ns); m_sub = int'(load_sub);
        end else begin
          t = m_ns + (m_sn ? int'(step_val) : inc);
          c = (t >= NS_ROLL) ? 1 : 0;
          m_ns = c ? t - NS_ROLL : t;
          m_sec = m_sec + c;
          if (m_ss) m_sec = step_neg ? m_sec - int'(step_val) : m_sec + int'(step_val);
          m_sec = ((m_sec % 256) + 256) % 256;
          m_sub = s % 256;
        end
        m_ld = go_ld; m_ss = go_ss; m_sn = go_sn;
        if (go_tmp) begin
          m_tp = 1; m_rem = (tmp_len == 0) ? 1 : int'(tmp_len);
        end else if (m_tp) begin
          if (m_rem <= 1) begin m_tp = 0; m_rem = 0; end
          else m_rem = m_rem - 1;
        end
      end
      m_r1 = m_r0;
      m_r0 = 1;
    end
  end

  task automatic compare();
    logic [3:0] eb;
    eb = {m_tp, m_sn, m_ss, m_ld};
    n_vec++;
    if (int'(sec) != m_sec || int'(ns) != m_ns || int'(sub) != m_sub || busy != eb) begin
      n_bad++;
      $display("FAIL %s cyc %0d: got sec=%0d ns=%0d sub=%0d busy=%b exp sec=%0d ns=%0d sub=%0d busy=%b",
               tag, cyc, sec, ns, sub, busy, m_sec, m_ns, m_sub, eb);
    end
  endtask

  task automatic run(input int n);
    repeat (n) begin
      @(negedge clk);
      cyc++;
      compare();
    end
  endtask

  task automatic clear_go();
    go_ld = 0; go_ss = 0; go_sn = 0; go_tmp = 0;
  endtask

  initial begin
    // R1: reset and synchronous release
    tag = "R1";
    run(4);
    rst_n = 1'b1;
    run(4);

    // R2 and R4: nominal stepping, rollover, seconds wrap
    tag = "R2";
    rate_adj = 8'd0;
    run(40);
    tag = "R4";
    load_sec = 8'd255; load_ns = 7'd95; load_sub = 8'd0;
    go_ld = 1; run(1); clear_go(); run(25);

    // R3: every trim value in both directions
    tag = "R3";
    for (int d = 0; d < 2; d++) begin
      for (int r = 0; r < 256; r++) begin
        rate_adj = r[7:0]; rate_fast = d[0];
        run(6);
      end
    end

    // R5: loads across the nanoseconds range
    tag = "R5";
    rate_adj = 8'd77; rate_fast = 1'b1;
    for (int v = 0; v < NS_ROLL; v += 3) begin
      load_sec = 8'((v * 37) % 256); load_ns = 7'(v); load_sub = 8'((v * 11) % 256);
      go_ld = 1; run(1); clear_go(); run(3);
    end

    // R6: every seconds step, both directions, with trim running
    tag = "R6";
    rate_adj = 8'd150; rate_fast = 1'b0;
    for (int d = 0; d < 2; d++) begin
      for (int v = 0; v < 256; v++) begin
        step_val = v[7:0]; step_neg = d[0];
        go_ss = 1; run(1); clear_go(); run(2);
      end
    end

    // R7: every legal nanoseconds step, coinciding with carries
    tag = "R7";
    rate_adj = 8'd200; rate_fast = 1'b1;
    for (int v = 0; v < NS_ROLL; v++) begin
      step_val = v[7:0];
      go_sn = 1; run(1); clear_go(); run(2);
    end

    // R8: all combinations of load and step starts
    tag = "R8";
    load_sec = 8'd10; load_ns = 7'd50; load_sub = 8'd5;
    for (int k = 0; k < 8; k++) begin
      step_val = 8'd93; step_neg = k[0];
      go_ld = k[0]; go_ss = k[1]; go_sn = k[2];
      run(1); clear_go(); run(3);
    end

    // R9 and R10: temporary rate for a range of lengths
    tag = "R9";
    rate_adj = 8'd0; rate_fast = 1'b0;
    tmp_rate = 8'd255; tmp_fast = 1'b1;
    for (int d = 0; d < 24; d++) begin
      tmp_len = DUR_W'(d);
      go_tmp = 1; run(1); clear_go(); run(d + 4);
    end
    tag = "R10";
    go_ld = 1; go_ss = 1; run(2); clear_go(); run(3);

    // R11: restart while active
    tag = "R11";
    tmp_rate = 8'd128; tmp_fast = 1'b0;
    tmp_len = 6'd20; go_tmp = 1; run(1); clear_go(); run(5);
    tmp_len = 6'd3;  go_tmp = 1; run(1); clear_go(); run(8);
    tmp_len = 6'd63; go_tmp = 1; run(1); clear_go(); run(70);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule